// File: doc/BRIEF.md
# Beam-Axis Vertex Histogrammer

This block takes the straight-line track segments found in one projection, each given as a slope and an intercept, and works out where each line crosses the beam axis. It does not fit vertices iteratively. It drops every crossing into a coarse histogram along the axis, marks local maxima of that histogram as vertex candidates, and attaches each stored track to the closest candidate. Each candidate then yields one result: its mean axis position, a spread figure and the number of tracks attached to it.

Tracks enter one per handshake on a valid/ready stream. The beat that closes an event carries `in_last`. The block then stops taking input. It scans the histogram once, clearing each bin as it reads it, and walks its stored tracks once to assign them. It then sends the vertex records on a second valid/ready stream and marks the final record of the event with `out_last`. The limits on candidates per event and on tracks per vertex are fixed by parameters. Tracks that arrive for a vertex that is already full are counted and reported.

Top module: `vh_histogrammer`

## Requirements
- R1: A track with slope m and intercept b crosses the axis at z = floor(nb * Rk / 256), where nb = b when m < 0 and nb = -b otherwise, and Rk = floor(256 / |m|). Its bin is (z + 128) >> 2. Tracks whose bin falls outside 0..63 are ignored.
- R2: A track with slope 0 is ignored and adds nothing to any bin or vertex.
- R3: Bin i is a candidate when three conditions hold: count(i) >= peak_thr, count(i) >= count(i-1) and count(i) > count(i+1), with bins outside the range counted as 0. Candidates are kept in ascending bin order, and only the first 8 are kept.
- R4: Each stored track goes to the candidate whose bin is nearest its own, provided the distance is at most 2 bins. On a tie the lower bin wins. A track with no candidate within 2 bins is not assigned.
- R5: A vertex takes at most 8 tracks. Each further track assigned to it is discarded and counted in drop_count. drop_count is cleared by the end-of-event beat and holds its value until the next one.
- R6: Each vertex record gives out_ntrk = n, out_z = S / n rounded toward zero, and out_spread = (n*Q - S*S) / (n*n) rounded down, where S is the sum and Q the sum of squares of the z values of the attached tracks.
- R7: Vertex records leave in candidate order. out_last is set on the final record of the event. An event with no candidates sends no record. A record holds steady while out_ready is low.
- R8: in_ready drops in the cycle after the end-of-event beat and stays low until the last vertex record has been taken. Every bin is zero when the next event starts.
- R9: During and after reset, in_ready is 1, out_valid is 0 and drop_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| peak_thr | input | 6 | Minimum bin count for a candidate |
| in_valid | input | 1 | Track beat present |
| in_ready | output | 1 | Block accepts a track beat |
| in_slope | input | 6 | Signed track slope |
| in_icpt | input | 10 | Signed track intercept |
| in_last | input | 1 | Beat closes the event |
| out_valid | output | 1 | Vertex record present |
| out_ready | input | 1 | Consumer takes the record |
| out_z | output | 11 | Signed mean axis position |
| out_spread | output | 25 | Spread of attached crossings |
| out_ntrk | output | 4 | Attached track count |
| out_last | output | 1 | Final record of the event |
| drop_count | output | 6 | Tracks discarded on full vertices in the latest event |

## Verification
The bench uses slopes of both signs and of magnitude 2, 3 and 4. A wrong sign convention or a rounded reciprocal would move crossings into the wrong bin, and the floor of 256/3 shows up in the mean. Two equal neighbouring bins must produce exactly one candidate, on the right-hand bin. A track sitting exactly halfway between two candidates must go to the lower one, and a track three bins away must be left out. A design with a different comparison or window would change the track counts. Overfilling one vertex, offering nine peaks, giving zero-slope tracks and following a busy event with a sparse one probe the caps, the ignore rule and the clearing of the histogram. A design that got any of these wrong would report extra vertices, extra tracks or a wrong drop_count. An event with no candidates must end without any record, and records must hold steady under backpressure.

// File: rtl/vh_pkg.sv
package vh_pkg;
    typedef enum logic [1:0] {
        PH_ACC    = 2'd0,
        PH_SCAN   = 2'd1,
        PH_ASSIGN = 2'd2,
        PH_EMIT   = 2'd3
    } phase_e;
endpackage

// File: rtl/vh_project.sv
// Beam-axis crossing of one track: reciprocal table, multiply, shift, bin.
module vh_project #(
    parameter int SLOPE_W   = 6,
    parameter int ICPT_W    = 10,
    parameter int FRAC      = 8,
    parameter int NBINS     = 64,
    parameter int BIN_SHIFT = 2,
    parameter int Z_MIN     = -128,
    localparam int Z_W      = ICPT_W + 1,
    localparam int BIN_W    = $clog2(NBINS)
) (
    input  logic signed [SLOPE_W-1:0] slope,
    input  logic signed [ICPT_W-1:0]  icpt,
    output logic signed [Z_W-1:0]     z,
    output logic [BIN_W-1:0]          bin,
    output logic                      ok
);
    localparam int MAG_MAX = 1 << (SLOPE_W - 1);
    localparam int R_W     = FRAC + 1;
    localparam int P_W     = Z_W + R_W + 1;

    logic [R_W-1:0] rtab [MAG_MAX+1];
    assign rtab[0] = '0;
    for (genvar k = 1; k <= MAG_MAX; k++) begin : g_rtab
        assign rtab[k] = R_W'((1 << FRAC) / k);
    end

    logic [SLOPE_W-1:0]    mag;
    logic signed [Z_W-1:0] nb;
    logic signed [P_W-1:0] prod;
    logic signed [P_W-1:0] off;

    always_comb begin
        mag  = slope[SLOPE_W-1] ? SLOPE_W'(-slope) : SLOPE_W'(slope);
        nb   = slope[SLOPE_W-1] ? Z_W'(icpt) : -Z_W'(icpt);
        prod = P_W'(nb) * $signed({1'b0, rtab[mag]});
        z    = Z_W'(prod >>> FRAC);
        off  = P_W'(z) - P_W'(Z_MIN);
        ok   = (slope != '0) && !off[P_W-1]
               && (off < P_W'(NBINS << BIN_SHIFT));
        bin  = BIN_W'(off >>> BIN_SHIFT);
    end
endmodule

// File: rtl/vh_assign.sv
// Nearest candidate within a bin window; the lower bin wins a tie.
module vh_assign #(
    parameter int MAX_VTX = 8,
    parameter int BIN_W   = 6,
    parameter int WIN     = 2,
    localparam int VTX_W  = $clog2(MAX_VTX)
) (
    input  logic [BIN_W-1:0]                bin,
    input  logic [MAX_VTX-1:0][BIN_W-1:0]   cbin,
    input  logic [VTX_W:0]                  ncand,
    output logic                            hit,
    output logic [VTX_W-1:0]                sel
);
    logic [BIN_W-1:0] d;
    logic [BIN_W:0]   best;

    always_comb begin
        hit  = 1'b0;
        sel  = '0;
        best = (BIN_W+1)'(WIN + 1);
        d    = '0;
        for (int k = 0; k < MAX_VTX; k++) begin
            d = (bin > cbin[k]) ? bin - cbin[k] : cbin[k] - bin;
            if (((VTX_W+1)'(k) < ncand) && ({1'b0, d} < best)) begin
                hit  = 1'b1;
                sel  = VTX_W'(k);
                best = {1'b0, d};
            end
        end
    end
endmodule

// File: rtl/vh_moments.sv
// Mean and spread of one vertex from its count, sum and sum of squares.
module vh_moments #(
    parameter int TPV_W = 4,
    parameter int SUM_W = 15,
    parameter int SQ_W  = 25,
    parameter int Z_W   = 11
) (
    input  logic [TPV_W-1:0]        n,
    input  logic signed [SUM_W-1:0] sum,
    input  logic [SQ_W-1:0]         sq,
    output logic signed [Z_W-1:0]   mean,
    output logic [SQ_W-1:0]         spread
);
    localparam int W = SQ_W + 2 * TPV_W + 2;

    logic signed [W-1:0] nw, sw, qw;

    always_comb begin
        nw = $signed(W'(n));
        sw = W'(sum);
        qw = $signed(W'(sq));
        if (n == '0) begin
            mean   = '0;
            spread = '0;
        end else begin
            mean   = Z_W'(sw / nw);
            spread = SQ_W'((nw * qw - sw * sw) / (nw * nw));
        end
    end
endmodule

// File: rtl/vh_histogrammer.sv
module vh_histogrammer #(
    parameter int SLOPE_W   = 6,
    parameter int ICPT_W    = 10,
    parameter int FRAC      = 8,
    parameter int NBINS     = 64,
    parameter int BIN_SHIFT = 2,
    parameter int Z_MIN     = -128,
    parameter int TRK_MAX   = 32,
    parameter int MAX_VTX   = 8,
    parameter int MAX_TPV   = 8,
    parameter int WIN       = 2,
    localparam int Z_W      = ICPT_W + 1,
    localparam int CNT_W    = $clog2(TRK_MAX + 1),
    localparam int TPV_W    = $clog2(MAX_TPV + 1),
    localparam int SQ_W     = 2 * Z_W + $clog2(MAX_TPV)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CNT_W-1:0]          peak_thr,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic signed [SLOPE_W-1:0] in_slope,
    input  logic signed [ICPT_W-1:0]  in_icpt,
    input  logic                      in_last,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic signed [Z_W-1:0]     out_z,
    output logic [SQ_W-1:0]           out_spread,
    output logic [TPV_W-1:0]          out_ntrk,
    output logic                      out_last,
    output logic [CNT_W-1:0]          drop_count
);
    import vh_pkg::*;

    localparam int BIN_W = $clog2(NBINS);
    localparam int TI_W  = $clog2(TRK_MAX);
    localparam int VTX_W = $clog2(MAX_VTX);
    localparam int SUM_W = Z_W + $clog2(MAX_TPV) + 1;
    localparam int IDX_W = $clog2(NBINS + TRK_MAX + MAX_VTX) + 1;

    typedef struct packed {
        phase_e                              phase;
        logic [NBINS-1:0][CNT_W-1:0]         hist;
        logic [TRK_MAX-1:0][Z_W-1:0]         tz;
        logic [TRK_MAX-1:0][BIN_W-1:0]       tb;
        logic [CNT_W-1:0]                    ntrk;
        logic [IDX_W-1:0]                    idx;
        logic [CNT_W-1:0]                    prev;
        logic [VTX_W:0]                      ncand;
        logic [MAX_VTX-1:0][BIN_W-1:0]       cbin;
        logic [MAX_VTX-1:0][TPV_W-1:0]       vn;
        logic [MAX_VTX-1:0][SUM_W-1:0]       vsum;
        logic [MAX_VTX-1:0][SQ_W-1:0]        vsq;
        logic [CNT_W-1:0]                    drop;
    } state_t;

    state_t s_d, s_q;

    logic signed [Z_W-1:0]   p_z;
    logic [BIN_W-1:0]        p_bin;
    logic                    p_ok;
    logic                    a_hit;
    logic [VTX_W-1:0]        a_sel;
    logic [BIN_W-1:0]        a_bin;
    logic [VTX_W-1:0]        ei;
    logic [BIN_W-1:0]        bi;
    logic [CNT_W-1:0]        cur, right;
    logic                    peak, last_v;
    logic signed [Z_W-1:0]   az;
    logic signed [2*Z_W-1:0] zsq;

    vh_project #(
        .SLOPE_W(SLOPE_W), .ICPT_W(ICPT_W), .FRAC(FRAC), .NBINS(NBINS),
        .BIN_SHIFT(BIN_SHIFT), .Z_MIN(Z_MIN)
    ) i_project (
        .slope(in_slope), .icpt(in_icpt), .z(p_z), .bin(p_bin), .ok(p_ok)
    );

    assign a_bin = s_q.tb[s_q.idx[TI_W-1:0]];

    vh_assign #(.MAX_VTX(MAX_VTX), .BIN_W(BIN_W), .WIN(WIN)) i_assign (
        .bin(a_bin), .cbin(s_q.cbin), .ncand(s_q.ncand), .hit(a_hit), .sel(a_sel)
    );

    assign ei = s_q.idx[VTX_W-1:0];

    vh_moments #(.TPV_W(TPV_W), .SUM_W(SUM_W), .SQ_W(SQ_W), .Z_W(Z_W)) i_moments (
        .n(s_q.vn[ei]), .sum(s_q.vsum[ei]), .sq(s_q.vsq[ei]),
        .mean(out_z), .spread(out_spread)
    );

    assign bi     = s_q.idx[BIN_W-1:0];
    assign last_v = (s_q.idx + 1'b1) == IDX_W'(s_q.ncand);

    always_comb begin
        s_d   = s_q;
        cur   = s_q.hist[bi];
        right = (bi == BIN_W'(NBINS - 1)) ? '0 : s_q.hist[bi + 1'b1];
        peak  = (cur >= peak_thr) && (cur >= s_q.prev) && (cur > right);
        az    = $signed(s_q.tz[s_q.idx[TI_W-1:0]]);
        zsq   = az * az;
        case (s_q.phase)
            PH_ACC: begin
                if (in_valid) begin
                    if (p_ok && (s_q.ntrk < CNT_W'(TRK_MAX))) begin
                        s_d.hist[p_bin]               = s_q.hist[p_bin] + 1'b1;
                        s_d.tz[s_q.ntrk[TI_W-1:0]]    = p_z;
                        s_d.tb[s_q.ntrk[TI_W-1:0]]    = p_bin;
                        s_d.ntrk                      = s_q.ntrk + 1'b1;
                    end
                    if (in_last) begin
                        s_d.phase = PH_SCAN;
                        s_d.idx   = '0;
                        s_d.prev  = '0;
                        s_d.ncand = '0;
                        s_d.vn    = '0;
                        s_d.vsum  = '0;
                        s_d.vsq   = '0;
                        s_d.drop  = '0;
                    end
                end
            end
            PH_SCAN: begin
                if (peak && (s_q.ncand < (VTX_W+1)'(MAX_VTX))) begin
                    s_d.cbin[s_q.ncand[VTX_W-1:0]] = bi;
                    s_d.ncand                      = s_q.ncand + 1'b1;
                end
                s_d.prev     = cur;
                s_d.hist[bi] = '0;
                if (s_q.idx == IDX_W'(NBINS - 1)) begin
                    s_d.phase = PH_ASSIGN;
                    s_d.idx   = '0;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            PH_ASSIGN: begin
                if (s_q.idx < IDX_W'(s_q.ntrk)) begin
                    if (a_hit) begin
                        if (s_q.vn[a_sel] < TPV_W'(MAX_TPV)) begin
                            s_d.vn[a_sel]   = s_q.vn[a_sel] + 1'b1;
                            s_d.vsum[a_sel] = s_q.vsum[a_sel] + SUM_W'(az);
                            s_d.vsq[a_sel]  = s_q.vsq[a_sel] + SQ_W'(zsq);
                        end else begin
                            s_d.drop = s_q.drop + 1'b1;
                        end
                    end
                    s_d.idx = s_q.idx + 1'b1;
                end else begin
                    s_d.ntrk  = '0;
                    s_d.idx   = '0;
                    s_d.phase = (s_q.ncand == '0) ? PH_ACC : PH_EMIT;
                end
            end
            PH_EMIT: begin
                if (out_ready) begin
                    if (last_v) begin
                        s_d.phase = PH_ACC;
                        s_d.idx   = '0;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            default: s_d.phase = PH_ACC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_ready   = (s_q.phase == PH_ACC);
    assign out_valid  = (s_q.phase == PH_EMIT);
    assign out_ntrk   = s_q.vn[ei];
    assign out_last   = out_valid && last_v;
    assign drop_count = s_q.drop;
endmodule

// File: rtl/vh_checker.sv
module vh_checker #(
    parameter int MAX_TPV = 8,
    parameter int CNT_W   = 6,
    parameter int Z_W     = 11,
    parameter int SQ_W    = 25,
    parameter int TPV_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_last,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_last,
    input logic [Z_W-1:0]   out_z,
    input logic [SQ_W-1:0]  out_spread,
    input logic [TPV_W-1:0] out_ntrk,
    input logic [CNT_W-1:0] drop_count
);
    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && in_ready && drop_count == '0));

    assert_record_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_z) && $stable(out_spread)
                                    && $stable(out_ntrk) && $stable(out_last));

    assert_event_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid);

    assert_busy_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_last |=> !in_ready);

    assert_vertex_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_ntrk <= TPV_W'(MAX_TPV)) && (out_ntrk != '0));

    assert_drop_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> $stable(drop_count));
endmodule

bind vh_histogrammer vh_checker #(
    .MAX_TPV(MAX_TPV), .CNT_W(CNT_W), .Z_W(Z_W), .SQ_W(SQ_W), .TPV_W(TPV_W)
) u_chk (.*);

// File: tb/test_vh_histogrammer.sv
module test_vh_histogrammer;
    localparam int CLK_P = 10;
    localparam int SW    = 6;
    localparam int IW    = 10;
    localparam int NT    = 28;
    localparam int NV    = 6;

    // Track table: slope, intercept, end-of-event flag.
    localparam int TM [NT] = '{1,1,1,1,1,1,1,  -1,2,3,-4,  1,1,1,1,1,1,1,1,1,  1,1,1,1,1,1,1,1};
    localparam int TB [NT] = '{0,-1,-2,-3,-40,-41,-42,  10,-20,-30,40,
                               48,48,48,32,32,32,40,20,28,
                               -32,-32,-32,-36,-36,-36,-100,-100};
    localparam int TL [NT] = '{0,0,0,0,0,0,1,  0,0,0,1,  0,0,0,0,0,0,0,0,1,  0,0,0,0,0,0,0,1};
    // Expected vertex records: z, spread, count, last.
    localparam int EZ [NV] = '{1, 41, 9, -46, -31, 34};
    localparam int ES [NV] = '{1, 0, 0, 12, 3, 4};
    localparam int EN [NV] = '{4, 3, 4, 4, 4, 6};
    localparam int EL [NV] = '{0, 1, 1, 0, 1, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] peak_thr = 6'd3;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [SW-1:0] in_slope = '0;
    logic signed [IW-1:0] in_icpt = '0;
    logic in_last = 1'b0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic signed [10:0] out_z;
    logic [24:0] out_spread;
    logic [3:0] out_ntrk;
    logic out_last;
    logic [5:0] drop_count;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    vh_histogrammer i_vh_histogrammer (
        .clk(clk), .rst_n(rst_n), .peak_thr(peak_thr),
        .in_valid(in_valid), .in_ready(in_ready), .in_slope(in_slope),
        .in_icpt(in_icpt), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_z(out_z),
        .out_spread(out_spread), .out_ntrk(out_ntrk), .out_last(out_last),
        .drop_count(drop_count)
    );

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
            $finish;
        end
    endtask

    task automatic send(int m, int b, bit last);
        @(negedge clk);
        in_valid = 1'b1;
        in_slope = SW'(m);
        in_icpt  = IW'(b);
        in_last  = last;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic expect_vtx(int ez, int es, int en, int el, string tag);
        int guard = 0;
        @(negedge clk);
        while (!out_valid && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk({tag, " valid"}, int'(out_valid), 1);
        chk({tag, " z"}, int'(out_z), ez);
        chk({tag, " spread"}, int'(out_spread), es);
        chk({tag, " ntrk"}, int'(out_ntrk), en);
        chk({tag, " last"}, int'(out_last), el);
    endtask

    task automatic after_event(int exp_drop, string tag);
        @(negedge clk);
        chk({tag, " drop_count"}, int'(drop_count), exp_drop);
        chk({tag, " in_ready back"}, int'(in_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int vptr = 0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 in_ready", int'(in_ready), 1);
        chk("R9 out_valid", int'(out_valid), 0);
        chk("R9 drop_count", int'(drop_count), 0);
        rst_n = 1'b1;

        // Table walk: R1 projection and rounding, R3 plateau and threshold,
        // R4 nearest/tie/window, R6 moments.
        for (int i = 0; i < NT; i++) begin
            send(TM[i], TB[i], TL[i] != 0);
            if (TL[i] != 0) begin
                chk("R8 in_ready low after end beat", int'(in_ready), 0);
                do begin
                    expect_vtx(EZ[vptr], ES[vptr], EN[vptr], EL[vptr], "R1/R3/R4/R6 table");
                    vptr++;
                end while (EL[vptr-1] == 0);
                after_event(0, "R5 table");
            end
        end

        // R5: overfilled vertex, two tracks discarded
        for (int k = 0; k < 10; k++) send(1, 0, k == 9);
        expect_vtx(0, 0, 8, 1, "R5 full vertex");
        after_event(2, "R5 overflow");

        // R2 zero slope ignored, R1 out of range ignored, R8 bins cleared
        for (int k = 0; k < 3; k++) send(0, 5, 1'b0);
        send(1, 0, 1'b0);
        send(1, 0, 1'b0);
        for (int k = 0; k < 3; k++) send(1, 20, 1'b0);
        for (int k = 0; k < 3; k++) send(1, -200, k == 2);
        expect_vtx(-20, 0, 3, 1, "R2/R8 ignore and clear");
        after_event(0, "R2 after");

        // R7: backpressure holds the record
        out_ready = 1'b0;
        for (int i = 0; i < 7; i++) send(TM[i], TB[i], TL[i] != 0);
        begin
            int guard = 0;
            while (!out_valid && guard < 2000) begin @(negedge clk); guard++; end
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R7 hold valid", int'(out_valid), 1);
            chk("R7 hold z", int'(out_z), 1);
            chk("R8 in_ready low while emitting", int'(in_ready), 0);
        end
        out_ready = 1'b1;
        chk("R7 first ntrk", int'(out_ntrk), 4);
        chk("R7 first last", int'(out_last), 0);
        expect_vtx(41, 0, 3, 1, "R7 second record");
        after_event(0, "R7 after");

        // R3: nine peaks, only the lowest eight kept
        for (int p = 0; p < 9; p++)
            for (int k = 0; k < 3; k++) send(1, 128 - 16 * p, (p == 8) && (k == 2));
        for (int p = 0; p < 8; p++)
            expect_vtx(-128 + 16 * p, 0, 3, (p == 7) ? 1 : 0, "R3 candidate cap");
        after_event(0, "R3 cap");

        // R3: lowered threshold turns a pair into a vertex
        peak_thr = 6'd2;
        send(1, -100, 1'b0);
        send(1, -100, 1'b1);
        expect_vtx(100, 0, 2, 1, "R3 threshold 2");
        after_event(0, "R3 threshold");
        peak_thr = 6'd3;

        // R7: event with no candidate sends nothing
        send(1, -300, 1'b1);
        begin
            int seen = 0;
            for (int k = 0; k < 120; k++) begin
                @(negedge clk);
                if (out_valid) seen++;
            end
            chk("R7 empty event records", seen, 0);
        end
        chk("R7 empty event in_ready", int'(in_ready), 1);

        summary();
    end
endmodule